// File: doc/BRIEF.md
# String Transfer Address Sequencer

This block runs string-style data transfers for a processor core. It executes one element, or a counted series of elements, of three kinds: a load from memory into the accumulator, a store from the accumulator into memory, and a memory-to-memory move. It holds a source index, a destination index and a repeat count. For each element it issues requests on a simple memory port. Each request is tagged with a segment selector and a byte address. After each element it steps the index registers that the operation used.

A command gives the operation, the element size and a repeat enable. It is accepted while the block is idle, and the direction flag is sampled with it. The step is the element size in bytes. It is added when the direction flag is clear and subtracted when it is set. The index and count registers are loaded through a small write port while the block is idle, and their values are always visible on output ports. When the command ends, a one-cycle completion pulse marks it.

Top module: `strx_seq`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1, `done` is 0, `mem_req_valid` is 0 and `acc_we` is 0. The source index, destination index and count all read 0.
- R2: Load (op code 0) issues one read per element. The read uses the data segment (`mem_req_seg`=0) at the source index. The returned data is then written to the accumulator with byte enables 0x1, 0x3 or 0xF for size codes 0, 1 and 2. Only the source index steps.
- R3: Store (op code 1) issues one write per element. The write uses the extra segment (`mem_req_seg`=1) at the destination index, and its data is the accumulator's low bytes for the element size. Only the destination index steps.
- R4: Move (op code 2) reads through the data segment at the source index. After the read response returns, it writes the same element through the extra segment at the destination index. Both indices step only after that write is accepted.
- R5: The step is 1, 2 or 4 bytes for size codes 0 (byte), 1 (word) and 2 (doubleword). It is an increment when the direction flag is 0 and a decrement when it is 1. Indices wrap modulo 2^IDX_W.
- R6: Data lanes are little-endian: bus bits [8k+7:8k] carry the byte at address+k. Lanes above the element size are 0 on write data and on accumulator write data.
- R7: With repeat set, the count drops by one per element and the command ends when it reaches 0. A repeat command that starts with a count of 0 performs no memory access and no accumulator write, and changes no register.
- R8: With repeat clear, exactly one element is performed and the count is left unchanged.
- R9: `cmd_ready` is 0 from the cycle after acceptance until the command ends. `done` is high for exactly one cycle at the end, and `cmd_ready` returns to 1 in the next cycle.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address, segment, direction, size and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken while `cmd_ready` is high |
| cmd_op | input | 2 | Operation: 0 load, 1 store, 2 move |
| cmd_size | input | 2 | Element size: 0 byte, 1 word, 2 doubleword |
| cmd_rep | input | 1 | Repeat under the count register |
| dir_flag | input | 1 | 0 steps indices up, 1 steps them down |
| cmd_ready | output | 1 | Idle and able to accept a command |
| done | output | 1 | One-cycle completion pulse |
| reg_wr_en | input | 1 | Register load strobe, used while idle |
| reg_sel | input | 2 | Register selector: 0 source, 1 destination, 2 count |
| reg_wdata | input | IDX_W | Register load value (count takes the low CNT_W bits) |
| src_idx | output | IDX_W | Current source index |
| dst_idx | output | IDX_W | Current destination index |
| count | output | CNT_W | Current repeat count |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_seg | output | 1 | Segment selector: 0 data, 1 extra |
| mem_req_addr | output | IDX_W | Byte address (index value) |
| mem_req_size | output | 2 | Element size code of the request |
| mem_req_wdata | output | DW | Write data, little-endian lanes |
| mem_rsp_valid | input | 1 | Read data present, one cycle |
| mem_rsp_rdata | input | DW | Read data, little-endian lanes |
| acc_rdata | input | DW | Accumulator value for stores |
| acc_we | output | 1 | Accumulator write strobe |
| acc_be | output | DW/8 | Accumulator byte enables |
| acc_wdata | output | DW | Accumulator write data |

## Verification
A request accepted on a rising edge is followed by read data that the bench returns in the next cycle. The matching accumulator write appears one cycle after that data. A move's write request appears in the same cycle as the accumulator write would, and the indices change on the edge that accepts the write or retires the accumulator write. The completion pulse follows the last element by one cycle, and the idle flag returns one cycle after that. The bench drives and samples on the falling edge, between those rising edges. The scoreboard compares each request or accumulator write in the cycle in which it is offered. Register values are compared only in the cycle after the pulse, once every update is certain to have landed.

// File: rtl/strx_pkg.sv
package strx_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_MOVE  = 2'd2,
      OP_RSVD  = 2'd3
   } strx_op_e;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RD_REQ  = 3'd1,
      ST_RD_WAIT = 3'd2,
      ST_LD_WB   = 3'd3,
      ST_WR_REQ  = 3'd4,
      ST_DONE    = 3'd5
   } strx_state_e;

   typedef struct packed {
      strx_op_e    op;
      logic [1:0]  sz;
      logic        rep;
      logic        dir;
   } strx_cmd_t;

   localparam logic SEG_DATA  = 1'b0;
   localparam logic SEG_EXTRA = 1'b1;

   localparam logic [1:0] SEL_SRC = 2'd0;
   localparam logic [1:0] SEL_DST = 2'd1;
   localparam logic [1:0] SEL_CNT = 2'd2;

endpackage

// File: rtl/strx_step.sv
module strx_step #(
   parameter int IDX_W = 32
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [1:0]       sz,
   input  logic             dir,
   output logic [IDX_W-1:0] nxt
);

   logic [IDX_W-1:0] delta;

   assign delta = IDX_W'(1) << sz;
   assign nxt   = dir ? (idx - delta) : (idx + delta);

endmodule

// File: rtl/strx_lane.sv
module strx_lane #(
   parameter int DW = 32
) (
   input  logic [1:0]      sz,
   input  logic [DW-1:0]   din,
   output logic [DW-1:0]   dout,
   output logic [DW/8-1:0] be
);

   localparam int NB = DW / 8;

   logic [3:0] nbytes;

   assign nbytes = 4'd1 << sz;

   for (genvar k = 0; k < NB; k++) begin : g_lane
      localparam logic [3:0] LANE = 4'(k);
      assign be[k]           = (LANE < nbytes);
      assign dout[8*k +: 8]  = be[k] ? din[8*k +: 8] : 8'h00;
   end

endmodule

// File: rtl/strx_ctrl.sv
module strx_ctrl
   import strx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  strx_cmd_t   cmd_in,
   input  logic        cnt_zero,
   input  logic        cnt_one,
   input  logic        mem_req_ready,
   input  logic        mem_rsp_valid,
   output strx_state_e state,
   output strx_cmd_t   cmd_q,
   output logic        elem_done,
   output logic        rsp_take
);

   strx_state_e start_st;
   strx_state_e first_st;
   strx_state_e after_st;

   always_comb begin
      start_st  = (cmd_in.op == OP_STORE) ? ST_WR_REQ : ST_RD_REQ;
      first_st  = (cmd_in.rep && cnt_zero) ? ST_DONE : start_st;
      after_st  = (!cmd_q.rep || cnt_one) ? ST_DONE :
                  ((cmd_q.op == OP_STORE) ? ST_WR_REQ : ST_RD_REQ);
      elem_done = (state == ST_LD_WB) || ((state == ST_WR_REQ) && mem_req_ready);
      rsp_take  = (state == ST_RD_WAIT) && mem_rsp_valid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cmd_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (cmd_valid) begin
                  cmd_q <= cmd_in;
                  state <= first_st;
               end
            end
            ST_RD_REQ: begin
               if (mem_req_ready) state <= ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
               if (mem_rsp_valid) state <= (cmd_q.op == OP_MOVE) ? ST_WR_REQ : ST_LD_WB;
            end
            ST_LD_WB: begin
               state <= after_st;
            end
            ST_WR_REQ: begin
               if (mem_req_ready) state <= after_st;
            end
            ST_DONE: begin
               state <= ST_IDLE;
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/strx_seq.sv
module strx_seq
   import strx_pkg::*;
#(
   parameter int IDX_W = 32,
   parameter int CNT_W = 16,
   parameter int DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [1:0]       cmd_size,
   input  logic             cmd_rep,
   input  logic             dir_flag,
   output logic             cmd_ready,
   output logic             done,
   input  logic             reg_wr_en,
   input  logic [1:0]       reg_sel,
   input  logic [IDX_W-1:0] reg_wdata,
   output logic [IDX_W-1:0] src_idx,
   output logic [IDX_W-1:0] dst_idx,
   output logic [CNT_W-1:0] count,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic             mem_req_write,
   output logic             mem_req_seg,
   output logic [IDX_W-1:0] mem_req_addr,
   output logic [1:0]       mem_req_size,
   output logic [DW-1:0]    mem_req_wdata,
   input  logic             mem_rsp_valid,
   input  logic [DW-1:0]    mem_rsp_rdata,
   input  logic [DW-1:0]    acc_rdata,
   output logic             acc_we,
   output logic [DW/8-1:0]  acc_be,
   output logic [DW-1:0]    acc_wdata
);

   localparam int NB   = DW / 8;
   localparam int NIDX = 2;

   if (DW != 32) begin : g_bad_dw
      $error("strx_seq: DW must be 32");
   end
   if (CNT_W > IDX_W) begin : g_bad_cnt
      $error("strx_seq: CNT_W must not exceed IDX_W");
   end
   if (IDX_W < 8) begin : g_bad_idx
      $error("strx_seq: IDX_W must be at least 8");
   end

   strx_cmd_t   cmd_in;
   strx_cmd_t   cmd_q;
   strx_state_e state;
   logic        elem_done;
   logic        rsp_take;
   logic        cnt_zero;
   logic        cnt_one;
   logic        idle;

   logic [IDX_W-1:0] idx_q   [NIDX];
   logic [IDX_W-1:0] idx_nxt [NIDX];
   logic [NIDX-1:0]  idx_used;

   logic [CNT_W-1:0] cnt_q;
   logic [DW-1:0]    rd_buf;
   logic [DW-1:0]    rsp_masked;
   logic [DW-1:0]    acc_masked;
   logic [NB-1:0]    rd_be;
   logic [NB-1:0]    wr_be;

   assign cmd_in.op  = strx_op_e'(cmd_op);
   assign cmd_in.sz  = cmd_size;
   assign cmd_in.rep = cmd_rep;
   assign cmd_in.dir = dir_flag;

   assign cnt_zero = (cnt_q == '0);
   assign cnt_one  = (cnt_q == CNT_W'(1));
   assign idle     = (state == ST_IDLE);

   strx_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_in        (cmd_in),
      .cnt_zero      (cnt_zero),
      .cnt_one       (cnt_one),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .state         (state),
      .cmd_q         (cmd_q),
      .elem_done     (elem_done),
      .rsp_take      (rsp_take)
   );

   // Lane masking of returned read data and of the accumulator.
   strx_lane #(.DW(DW)) u_rd_lane (
      .sz   (cmd_q.sz),
      .din  (mem_rsp_rdata),
      .dout (rsp_masked),
      .be   (rd_be)
   );

   strx_lane #(.DW(DW)) u_wr_lane (
      .sz   (cmd_q.sz),
      .din  (acc_rdata),
      .dout (acc_masked),
      .be   (wr_be)
   );

   always_comb begin
      idx_used[0] = (cmd_q.op != OP_STORE);
      idx_used[1] = (cmd_q.op != OP_LOAD);
   end

   // Index 0 is the source, index 1 the destination.
   for (genvar j = 0; j < NIDX; j++) begin : g_idx
      localparam logic [1:0] MY_SEL = 2'(j);

      strx_step #(.IDX_W(IDX_W)) u_step (
         .idx (idx_q[j]),
         .sz  (cmd_q.sz),
         .dir (cmd_q.dir),
         .nxt (idx_nxt[j])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idx_q[j] <= '0;
         end else if (idle && reg_wr_en && (reg_sel == MY_SEL)) begin
            idx_q[j] <= reg_wdata;
         end else if (elem_done && idx_used[j]) begin
            idx_q[j] <= idx_nxt[j];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (idle && reg_wr_en && (reg_sel == SEL_CNT)) begin
         cnt_q <= reg_wdata[CNT_W-1:0];
      end else if (elem_done && cmd_q.rep) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_buf <= '0;
      end else if (rsp_take) begin
         rd_buf <= rsp_masked;
      end
   end

   assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
   assign mem_req_write = (state == ST_WR_REQ);
   assign mem_req_seg   = mem_req_write ? SEG_EXTRA : SEG_DATA;
   assign mem_req_addr  = mem_req_write ? idx_q[1] : idx_q[0];
   assign mem_req_size  = cmd_q.sz;
   assign mem_req_wdata = (cmd_q.op == OP_MOVE) ? rd_buf : acc_masked;

   assign acc_we    = (state == ST_LD_WB);
   assign acc_be    = rd_be & wr_be;
   assign acc_wdata = rd_buf;

   assign cmd_ready = idle;
   assign done      = (state == ST_DONE);
   assign src_idx   = idx_q[0];
   assign dst_idx   = idx_q[1];
   assign count     = cnt_q;

endmodule

// File: rtl/strx_seq_chk.sv
module strx_seq_chk #(
   parameter int IDX_W = 32,
   parameter int CNT_W = 16,
   parameter int DW    = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_ready,
   input logic             done,
   input logic             reg_wr_en,
   input logic [IDX_W-1:0] src_idx,
   input logic [IDX_W-1:0] dst_idx,
   input logic [CNT_W-1:0] count,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic             mem_req_write,
   input logic             mem_req_seg,
   input logic [IDX_W-1:0] mem_req_addr,
   input logic [1:0]       mem_req_size,
   input logic [DW-1:0]    mem_req_wdata,
   input logic             acc_we
);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) &&
         $stable(mem_req_seg) && $stable(mem_req_write) && $stable(mem_req_size) &&
         $stable(mem_req_wdata))); // R10

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> cmd_ready); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!mem_req_valid && !acc_we && !done)); // R9

   AST_READ_DATA_SEG: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write) |-> (mem_req_seg == 1'b0)); // R2

   AST_WRITE_EXTRA_SEG: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> (mem_req_seg == 1'b1)); // R3

   AST_ACC_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      acc_we |-> !mem_req_valid); // R2

   AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write && (mem_req_size == 2'd0)) |->
         (mem_req_wdata[DW-1:8] == '0)); // R6

   AST_IDX_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && !reg_wr_en) |=> ($stable(src_idx) && $stable(dst_idx))); // R5

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr_en |=> ((count == $past(count)) || (count == $past(count) - CNT_W'(1)))); // R7

   AST_COUNT_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((count == '0) && !reg_wr_en) |=> (count == '0)); // R7

endmodule

bind strx_seq strx_seq_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W), .DW(DW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_ready     (cmd_ready),
   .done          (done),
   .reg_wr_en     (reg_wr_en),
   .src_idx       (src_idx),
   .dst_idx       (dst_idx),
   .count         (count),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_write (mem_req_write),
   .mem_req_seg   (mem_req_seg),
   .mem_req_addr  (mem_req_addr),
   .mem_req_size  (mem_req_size),
   .mem_req_wdata (mem_req_wdata),
   .acc_we        (acc_we)
);

// File: tb/strx_seq_tb_top.sv
module strx_seq_tb_top;

   localparam int IDX_W = 32;
   localparam int CNT_W = 16;
   localparam int DW    = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic             cmd_valid;
   logic [1:0]       cmd_op;
   logic [1:0]       cmd_size;
   logic             cmd_rep;
   logic             dir_flag;
   logic             cmd_ready;
   logic             done;
   logic             reg_wr_en;
   logic [1:0]       reg_sel;
   logic [IDX_W-1:0] reg_wdata;
   logic [IDX_W-1:0] src_idx;
   logic [IDX_W-1:0] dst_idx;
   logic [CNT_W-1:0] count;
   logic             mem_req_valid;
   logic             mem_req_ready;
   logic             mem_req_write;
   logic             mem_req_seg;
   logic [IDX_W-1:0] mem_req_addr;
   logic [1:0]       mem_req_size;
   logic [DW-1:0]    mem_req_wdata;
   logic             mem_rsp_valid;
   logic [DW-1:0]    mem_rsp_rdata;
   logic [DW-1:0]    acc_rdata;
   logic             acc_we;
   logic [DW/8-1:0]  acc_be;
   logic [DW-1:0]    acc_wdata;

   strx_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W), .DW(DW)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_op        (cmd_op),
      .cmd_size      (cmd_size),
      .cmd_rep       (cmd_rep),
      .dir_flag      (dir_flag),
      .cmd_ready     (cmd_ready),
      .done          (done),
      .reg_wr_en     (reg_wr_en),
      .reg_sel       (reg_sel),
      .reg_wdata     (reg_wdata),
      .src_idx       (src_idx),
      .dst_idx       (dst_idx),
      .count         (count),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_write (mem_req_write),
      .mem_req_seg   (mem_req_seg),
      .mem_req_addr  (mem_req_addr),
      .mem_req_size  (mem_req_size),
      .mem_req_wdata (mem_req_wdata),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_rdata (mem_rsp_rdata),
      .acc_rdata     (acc_rdata),
      .acc_we        (acc_we),
      .acc_be        (acc_be),
      .acc_wdata     (acc_wdata)
   );

   // kind: 0 read request, 1 write request, 2 accumulator write
   typedef struct {
      int          kind;
      logic        seg;
      logic [31:0] addr;
      logic [1:0]  sz;
      logic [31:0] data;
      logic [3:0]  be;
   } exp_t;

   exp_t  sbq[$];
   string cur_req;
   int    n_chk  = 0;
   int    n_fail = 0;
   bit    finished = 1'b0;
   bit    stall_en = 1'b0;
   int    cyc = 0;
   bit    pend_rd = 1'b0;
   logic [31:0] pend_addr = '0;

   logic [31:0] m_src = '0;
   logic [31:0] m_dst = '0;
   logic [15:0] m_cnt = '0;

   function automatic logic [7:0] mem_byte(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {mem_byte(a + 32'd3), mem_byte(a + 32'd2), mem_byte(a + 32'd1), mem_byte(a)};
   endfunction

   function automatic logic [31:0] lane_mask(input logic [31:0] d, input logic [1:0] sz);
      case (sz)
         2'd0:    return {24'h0, d[7:0]};
         2'd1:    return {16'h0, d[15:0]};
         default: return d;
      endcase
   endfunction

   function automatic logic [3:0] be_of(input logic [1:0] sz);
      case (sz)
         2'd0:    return 4'h1;
         2'd1:    return 4'h3;
         default: return 4'hF;
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Memory model and scoreboard monitor, all on the falling edge.
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_req_ready = 1'b1;
         mem_rsp_valid = 1'b0;
         mem_rsp_rdata = '0;
      end else begin
         mem_rsp_valid = pend_rd;
         mem_rsp_rdata = pend_rd ? mem_word(pend_addr) : 32'h0;
         pend_rd = 1'b0;
         cyc++;
         mem_req_ready = !stall_en || ((cyc % 3) != 0);

         if (acc_we) begin
            if (sbq.size() == 0) begin
               chk(cur_req, "unexpected accumulator write R2", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               chk(cur_req, "acc write kind R2", 32'd2, 32'(e.kind));
               chk(cur_req, "acc data R6", acc_wdata, e.data);
               chk(cur_req, "acc byte enables R2", {28'h0, acc_be}, {28'h0, e.be});
            end
         end

         if (mem_req_valid && mem_req_ready) begin
            if (sbq.size() == 0) begin
               chk(cur_req, "unexpected memory request R7", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               chk(cur_req, "request kind R4", {31'h0, mem_req_write}, 32'(e.kind));
               chk(cur_req, "request segment R3", {31'h0, mem_req_seg}, {31'h0, e.seg});
               chk(cur_req, "request address R5", mem_req_addr, e.addr);
               chk(cur_req, "request size R5", {30'h0, mem_req_size}, {30'h0, e.sz});
               if (mem_req_write) begin
                  chk(cur_req, "write data R6", mem_req_wdata, e.data);
               end else begin
                  pend_rd   = 1'b1;
                  pend_addr = mem_req_addr;
               end
            end
         end
      end
   end

   task automatic set_regs(input logic [31:0] s, input logic [31:0] d, input logic [15:0] c);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = s;
      @(negedge clk);
      reg_sel = 2'd1; reg_wdata = d;
      @(negedge clk);
      reg_sel = 2'd2; reg_wdata = {16'h0, c};
      @(negedge clk);
      reg_wr_en = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
      m_src = s; m_dst = d; m_cnt = c;
   endtask

   task automatic run_cmd(input logic [1:0] op, input logic [1:0] sz, input bit rep,
                          input bit dir, input logic [31:0] acc, input string req);
      int          n;
      int          w;
      exp_t        e;
      logic [31:0] step;
      n    = rep ? int'(m_cnt) : 1;
      step = 32'd1 << sz;
      acc_rdata = acc;
      for (int i = 0; i < n; i++) begin
         if (op != 2'd1) begin
            e = '{0, 1'b0, m_src, sz, 32'h0, 4'h0};
            sbq.push_back(e);
         end
         if (op == 2'd0) begin
            e = '{2, 1'b0, 32'h0, sz, lane_mask(mem_word(m_src), sz), be_of(sz)};
            sbq.push_back(e);
         end
         if (op == 2'd1) begin
            e = '{1, 1'b1, m_dst, sz, lane_mask(acc, sz), 4'h0};
            sbq.push_back(e);
         end
         if (op == 2'd2) begin
            e = '{1, 1'b1, m_dst, sz, lane_mask(mem_word(m_src), sz), 4'h0};
            sbq.push_back(e);
         end
         if (op != 2'd1) m_src = dir ? (m_src - step) : (m_src + step);
         if (op != 2'd0) m_dst = dir ? (m_dst - step) : (m_dst + step);
      end
      if (rep) m_cnt = '0;
      cur_req = req;

      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_size = sz; cmd_rep = rep; dir_flag = dir;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(req, "cmd_ready low while busy R9", {31'h0, cmd_ready}, 32'd0);
      w = 0;
      while (!done && w < 5000) begin
         @(negedge clk);
         w++;
      end
      chk(req, "done pulse seen R9", {31'h0, done}, 32'd1);
      @(negedge clk);
      chk(req, "done lasts one cycle R9", {31'h0, done}, 32'd0);
      chk(req, "cmd_ready back R9", {31'h0, cmd_ready}, 32'd1);
      chk(req, "source index R5", src_idx, m_src);
      chk(req, "destination index R5", dst_idx, m_dst);
      chk(req, "count R7 R8", {16'h0, count}, {16'h0, m_cnt});
      chk(req, "all expected items seen", 32'(sbq.size()), 32'd0);
      sbq.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R9 watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      cmd_valid = 1'b0; cmd_op = '0; cmd_size = '0; cmd_rep = 1'b0; dir_flag = 1'b0;
      reg_wr_en = 1'b0; reg_sel = 2'd3; reg_wdata = '0; acc_rdata = '0;
      mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk("R1", "cmd_ready", {31'h0, cmd_ready}, 32'd1);
      chk("R1", "done", {31'h0, done}, 32'd0);
      chk("R1", "mem_req_valid", {31'h0, mem_req_valid}, 32'd0);
      chk("R1", "acc_we", {31'h0, acc_we}, 32'd0);
      chk("R1", "src_idx", src_idx, 32'h0);
      chk("R1", "dst_idx", dst_idx, 32'h0);
      chk("R1", "count", {16'h0, count}, 32'h0);

      // Single loads, several sizes and both directions (R2, R8)
      set_regs(32'h0000_0100, 32'h0000_0800, 16'd7);
      run_cmd(2'd0, 2'd0, 1'b0, 1'b0, 32'h0, "R2 load byte up R8");
      run_cmd(2'd0, 2'd1, 1'b0, 1'b1, 32'h0, "R2 load word down");
      run_cmd(2'd0, 2'd2, 1'b0, 1'b0, 32'h0, "R2 load dword up");

      // Single stores (R3, R6)
      run_cmd(2'd1, 2'd0, 1'b0, 1'b0, 32'hDEAD_BEEF, "R3 store byte up R6");
      run_cmd(2'd1, 2'd1, 1'b0, 1'b1, 32'hCAFE_F00D, "R3 store word down R6");
      run_cmd(2'd1, 2'd2, 1'b0, 1'b0, 32'h1234_5678, "R3 store dword up");

      // Repeated moves under memory back-pressure (R4, R7, R10)
      stall_en = 1'b1;
      set_regs(32'h0000_2000, 32'h0000_3000, 16'd3);
      run_cmd(2'd2, 2'd2, 1'b1, 1'b0, 32'h0, "R4 move dword rep up R7 R10");
      set_regs(32'h0000_2105, 32'h0000_3203, 16'd5);
      run_cmd(2'd2, 2'd0, 1'b1, 1'b1, 32'h0, "R4 move byte rep down R7");

      // Repeated store and load with stalls
      set_regs(32'h0000_0040, 32'h0000_4010, 16'd4);
      run_cmd(2'd1, 2'd1, 1'b1, 1'b1, 32'hA5A5_5A5A, "R3 store word rep down R7");
      run_cmd(2'd0, 2'd1, 1'b1, 1'b0, 32'h0, "R7 load with zero count");
      set_regs(32'h0000_0040, 32'h0000_4010, 16'd2);
      run_cmd(2'd0, 2'd1, 1'b1, 1'b0, 32'h0, "R2 load word rep up R7");
      stall_en = 1'b0;

      // Zero count repeat: nothing touched (R7)
      set_regs(32'h0000_1111, 32'h0000_2222, 16'd0);
      run_cmd(2'd2, 2'd2, 1'b1, 1'b0, 32'h0, "R7 move with zero count");
      run_cmd(2'd1, 2'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R7 store with zero count");

      // Wrap-around of the index (R5)
      set_regs(32'hFFFF_FFFE, 32'h0000_0001, 16'd2);
      run_cmd(2'd0, 2'd2, 1'b0, 1'b0, 32'h0, "R5 load dword wrap up R8");
      run_cmd(2'd1, 2'd1, 1'b0, 1'b1, 32'h0000_BEEF, "R5 store word wrap down R8");
      run_cmd(2'd2, 2'd1, 1'b1, 1'b0, 32'h0, "R5 move word wrap rep R4");

      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule